// File: doc/BRIEF.md
# Byte-Wide Conversion Result Port

This block presents a 14-bit conversion result (a 12-bit magnitude, a polarity flag and an overrange flag) to a host over an 8-bit bus. The bus is modelled as a data vector plus an output-enable. The enclosing pad logic turns these into three-state pins. The block holds the most recent result in a latch. A conversion sequencer loads that latch with a one-cycle new-data strobe.

Two ways of reading are offered. In direct mode the host selects the block with a chip-select and picks a byte with one of two byte enables. The byte appears on the bus one clock later. In handshake mode the block sends the two bytes by itself, high byte first. Before each byte it waits for the receiver to raise a send input, and it drives each byte for a single clock.

A rising edge on the mode input arms a single handshake transfer, taken at the next conversion. After that transfer the block falls back to direct reads. Holding the mode input high instead gives a transfer after every conversion. The mode input has to be tied or pulled low at the pad when it is not used, so that an open pin selects direct mode.

Top module: `result_byte_port`

## Requirements
- R1: During and right after reset, `bus_oe_o` is 0, `bus_o` is all zero and `hs_busy_o` is 0.
- R2: When no transfer is in progress and no transfer starts, `chip_sel_i`=1 with `lo_en_i`=1 and `hi_en_i`=0 gives, on the next cycle, `bus_oe_o`=1 and `bus_o` equal to latched magnitude bits 7..0.
- R3: The high byte carries magnitude bits 11..8 in bus bits 3..0, overrange in bit 4, polarity in bit 5, and zeros in bits 7..6. A direct read with `hi_en_i`=1 returns it, and this byte wins when both byte enables are high.
- R4: When no direct read is selected and no handshake byte is being sent, `bus_oe_o` is 0 and `bus_o` is all zero.
- R5: The result latch loads on every cycle with `result_valid_i`=1 and holds otherwise. A direct read sampled in the same cycle as the strobe still returns the previous result.
- R6: With `mode_i` low and no transfer armed, strobes start no handshake transfer.
- R7: A rising edge on `mode_i` arms exactly one transfer. It starts at the next strobe, even when `mode_i` has already returned low. Later strobes with `mode_i` low start nothing.
- R8: While `mode_i` is high, every strobe that arrives with no transfer in progress starts a transfer of that strobe's result.
- R9: A transfer first drives the high byte, then the low byte. Each byte is driven for exactly one cycle, in the cycle after `send_i` was sampled high while the block waited for it. The block waits for `send_i` without limit.
- R10: During a transfer the byte enables are ignored, and strobes neither start a second transfer nor change the bytes being sent. They do still load the latch.
- R11: `hs_busy_o` rises in the cycle after a transfer starts and stays high up to and including the cycle that drives the low byte. It is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Transfer mode: a rising edge arms one transfer, a high level repeats |
| chip_sel_i | input | 1 | Direct-read chip select, active high |
| lo_en_i | input | 1 | Direct-read low byte enable |
| hi_en_i | input | 1 | Direct-read high byte enable |
| send_i | input | 1 | Receiver ready for the next handshake byte |
| result_valid_i | input | 1 | New-result strobe from the sequencer |
| result_mag_i | input | MAG_W | Result magnitude |
| result_pol_i | input | 1 | Result polarity |
| result_ovr_i | input | 1 | Result overrange |
| bus_o | output | BUS_W | Bus data, zero when not driven |
| bus_oe_o | output | 1 | Bus output enable |
| hs_busy_o | output | 1 | Handshake transfer in progress |

## Verification
The bench builds the block with its defaults: a 12-bit magnitude and an 8-bit bus. With these values the high byte has two spare bits, so the zero fill above the flags is visible, and every magnitude bit appears on one of the two bytes. A behavioural model keeps the pending handshake bytes in a queue. Directed phases cover the one-shot arm, level mode and send stalls. A random phase then mixes strobes, enables and send pulses during transfers.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

    // Handshake sequencer states
    typedef enum logic [2:0] {
        HS_IDLE     = 3'd0,
        HS_WAIT_HI  = 3'd1,
        HS_DRIVE_HI = 3'd2,
        HS_WAIT_LO  = 3'd3,
        HS_DRIVE_LO = 3'd4
    } hs_state_e;

    function automatic logic hs_is_drive(hs_state_e s);
        return (s == HS_DRIVE_HI) || (s == HS_DRIVE_LO);
    endfunction

endpackage

// File: rtl/rbp_byte_pack.sv
// Splits a result into its bus-wide low and high bytes.
module rbp_byte_pack #(
    parameter int MAG_W = 12,
    parameter int BUS_W = 8
) (
    input  logic [MAG_W-1:0] mag_i,
    input  logic             pol_i,
    input  logic             ovr_i,
    output logic [BUS_W-1:0] lo_byte_o,
    output logic [BUS_W-1:0] hi_byte_o
);
    localparam int HI_MAG  = MAG_W - BUS_W;
    localparam int HI_USED = HI_MAG + 2;

    generate
        if (HI_MAG < 1 || HI_USED > BUS_W) begin : g_bad_width
            $error("rbp_byte_pack: magnitude and flags do not fit two bytes");
        end
    endgenerate

    always_comb begin
        lo_byte_o                 = mag_i[BUS_W-1:0];
        hi_byte_o                 = '0;
        hi_byte_o[HI_MAG-1:0]     = mag_i[MAG_W-1:BUS_W];
        hi_byte_o[HI_MAG]         = ovr_i;
        hi_byte_o[HI_MAG+1]       = pol_i;
    end

endmodule

// File: rtl/rbp_mode_arm.sv
// Remembers a rising edge of the mode input until a transfer consumes it.
module rbp_mode_arm (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mode_i,
    input  logic start_i,
    output logic armed_o
);
    typedef struct packed {
        logic mode_prev;
        logic armed;
    } arm_t;

    arm_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.mode_prev = mode_i;
        st_d.armed     = (st_q.armed | (mode_i & ~st_q.mode_prev)) & ~start_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign armed_o = st_q.armed;

endmodule

// File: rtl/rbp_hs_seq.sv
// Two-byte handshake sender: high byte, then low byte, each gated by send.
module rbp_hs_seq
    import rbp_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             send_i,
    input  logic [BUS_W-1:0] hi_byte_i,
    input  logic [BUS_W-1:0] lo_byte_i,
    output logic             drive_o,
    output logic [BUS_W-1:0] byte_o,
    output logic             busy_o,
    output logic             idle_o
);
    typedef struct packed {
        hs_state_e        state;
        logic [BUS_W-1:0] hi;
        logic [BUS_W-1:0] lo;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            HS_IDLE: begin
                if (start_i) begin
                    st_d.state = HS_WAIT_HI;
                    st_d.hi    = hi_byte_i;
                    st_d.lo    = lo_byte_i;
                end
            end
            HS_WAIT_HI:  if (send_i) st_d.state = HS_DRIVE_HI;
            HS_DRIVE_HI: st_d.state = HS_WAIT_LO;
            HS_WAIT_LO:  if (send_i) st_d.state = HS_DRIVE_LO;
            HS_DRIVE_LO: st_d.state = HS_IDLE;
            default:     st_d.state = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.state <= HS_IDLE;
            st_q.hi    <= '0;
            st_q.lo    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        drive_o = hs_is_drive(st_q.state);
        byte_o  = '0;
        if (st_q.state == HS_DRIVE_HI) byte_o = st_q.hi;
        if (st_q.state == HS_DRIVE_LO) byte_o = st_q.lo;
        busy_o  = (st_q.state != HS_IDLE);
        idle_o  = (st_q.state == HS_IDLE);
    end

endmodule

// File: rtl/result_byte_port.sv
// Result latch, direct byte reads and handshake transfers onto one bus.
module result_byte_port #(
    parameter int MAG_W = 12,
    parameter int BUS_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mode_i,
    input  logic             chip_sel_i,
    input  logic             lo_en_i,
    input  logic             hi_en_i,
    input  logic             send_i,
    input  logic             result_valid_i,
    input  logic [MAG_W-1:0] result_mag_i,
    input  logic             result_pol_i,
    input  logic             result_ovr_i,
    output logic [BUS_W-1:0] bus_o,
    output logic             bus_oe_o,
    output logic             hs_busy_o
);
    typedef struct packed {
        logic [MAG_W-1:0] mag;
        logic             pol;
        logic             ovr;
        logic             dir_oe;
        logic [BUS_W-1:0] dir_bus;
    } port_t;

    port_t st_d, st_q;

    logic [BUS_W-1:0] held_lo, held_hi, new_lo, new_hi;
    logic             armed, start;
    logic             seq_drive, seq_busy, seq_idle;
    logic [BUS_W-1:0] seq_byte;

    rbp_byte_pack #(.MAG_W(MAG_W), .BUS_W(BUS_W)) u_pack_held (
        .mag_i     (st_q.mag),
        .pol_i     (st_q.pol),
        .ovr_i     (st_q.ovr),
        .lo_byte_o (held_lo),
        .hi_byte_o (held_hi)
    );

    rbp_byte_pack #(.MAG_W(MAG_W), .BUS_W(BUS_W)) u_pack_new (
        .mag_i     (result_mag_i),
        .pol_i     (result_pol_i),
        .ovr_i     (result_ovr_i),
        .lo_byte_o (new_lo),
        .hi_byte_o (new_hi)
    );

    rbp_mode_arm u_arm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .mode_i  (mode_i),
        .start_i (start),
        .armed_o (armed)
    );

    assign start = seq_idle & result_valid_i & (mode_i | armed);

    rbp_hs_seq #(.BUS_W(BUS_W)) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start),
        .send_i    (send_i),
        .hi_byte_i (new_hi),
        .lo_byte_i (new_lo),
        .drive_o   (seq_drive),
        .byte_o    (seq_byte),
        .busy_o    (seq_busy),
        .idle_o    (seq_idle)
    );

    always_comb begin
        st_d         = st_q;
        st_d.dir_oe  = 1'b0;
        st_d.dir_bus = '0;
        if (result_valid_i) begin
            st_d.mag = result_mag_i;
            st_d.pol = result_pol_i;
            st_d.ovr = result_ovr_i;
        end
        if (seq_idle && !start && chip_sel_i) begin
            if (hi_en_i) begin
                st_d.dir_oe  = 1'b1;
                st_d.dir_bus = held_hi;
            end else if (lo_en_i) begin
                st_d.dir_oe  = 1'b1;
                st_d.dir_bus = held_lo;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        bus_oe_o  = seq_drive | st_q.dir_oe;
        bus_o     = seq_drive ? seq_byte : (st_q.dir_oe ? st_q.dir_bus : '0);
        hs_busy_o = seq_busy;
    end

endmodule

// File: rtl/result_byte_port_checker.sv
module result_byte_port_checker #(
    parameter int MAG_W = 12,
    parameter int BUS_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             mode_i,
    input logic             chip_sel_i,
    input logic             hi_en_i,
    input logic             send_i,
    input logic             result_valid_i,
    input logic [BUS_W-1:0] bus_o,
    input logic             bus_oe_o,
    input logic             hs_busy_o
);
    localparam int HI_USED = MAG_W - BUS_W + 2;

    a_r4_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_oe_o |-> (bus_o == '0));

    a_r9_one_cycle_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hs_busy_o && bus_oe_o) |=> !bus_oe_o);

    a_r9_byte_after_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hs_busy_o && bus_oe_o) |-> $past(send_i));

    a_r10_hold_without_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hs_busy_o && !send_i) |=> !bus_oe_o);

    a_r6_start_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hs_busy_o) |-> $past(result_valid_i));

    a_r8_level_mode_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hs_busy_o && result_valid_i && mode_i) |=> hs_busy_o);

    a_r11_busy_ends_on_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(hs_busy_o) |-> $past(bus_oe_o));

    a_r3_spare_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hs_busy_o && chip_sel_i && hi_en_i) |=> (bus_o[BUS_W-1:HI_USED] == '0));

endmodule

bind result_byte_port result_byte_port_checker #(.MAG_W(MAG_W), .BUS_W(BUS_W)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_i         (mode_i),
    .chip_sel_i     (chip_sel_i),
    .hi_en_i        (hi_en_i),
    .send_i         (send_i),
    .result_valid_i (result_valid_i),
    .bus_o          (bus_o),
    .bus_oe_o       (bus_oe_o),
    .hs_busy_o      (hs_busy_o)
);

// File: tb/result_byte_port_test.sv
module result_byte_port_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0, cs = 1'b0, lo_en = 1'b0, hi_en = 1'b0;
    logic        send = 1'b0, valid = 1'b0;
    logic [11:0] mag = '0;
    logic        pol = 1'b0, ovr = 1'b0;
    logic [7:0]  bus;
    logic        oe, busy;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    result_byte_port uut (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .chip_sel_i(cs),
        .lo_en_i(lo_en), .hi_en_i(hi_en), .send_i(send), .result_valid_i(valid),
        .result_mag_i(mag), .result_pol_i(pol), .result_ovr_i(ovr),
        .bus_o(bus), .bus_oe_o(oe), .hs_busy_o(busy)
    );

    // High byte per R3: mag[11:8] in bits 3..0, ovr bit 4, pol bit 5
    function automatic logic [7:0] hi_of(logic [11:0] m, logic p, logic o);
        return {2'b00, p, o, m[11:8]};
    endfunction

    // Behavioural reference model
    logic [11:0] m_mag;
    logic        m_pol, m_ovr;
    bit          m_arm, m_prev, m_drove, m_start;
    logic [7:0]  pend[$];
    bit          e_oe, e_busy;
    logic [7:0]  e_bus;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mag = '0; m_pol = 0; m_ovr = 0; m_arm = 0; m_prev = 0; m_drove = 0;
            pend.delete(); e_oe = 0; e_bus = '0; e_busy = 0;
        end else begin
            m_start = 0; e_oe = 0; e_bus = '0;
            if (m_drove) begin
                m_drove = 0;
            end else if (pend.size() > 0) begin
                if (send) begin
                    e_oe = 1; e_bus = pend.pop_front(); m_drove = 1;
                end
            end else begin
                m_start = valid && (mode || m_arm);
                if (m_start) begin
                    pend.push_back(hi_of(mag, pol, ovr));
                    pend.push_back(mag[7:0]);
                end else if (cs && hi_en) begin
                    e_oe = 1; e_bus = hi_of(m_mag, m_pol, m_ovr);
                end else if (cs && lo_en) begin
                    e_oe = 1; e_bus = m_mag[7:0];
                end
            end
            m_arm  = (m_arm || (mode && !m_prev)) && !m_start;
            m_prev = mode;
            if (valid) begin m_mag = mag; m_pol = pol; m_ovr = ovr; end
            e_busy = (pend.size() > 0) || m_drove;
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_tag, "model oe", oe, e_oe);
            chk(cur_tag, "model bus", bus, e_bus);
            chk(cur_tag, "model busy", busy, e_busy);
        end
    end

    task automatic cyc(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        chk("R1", "oe", oe, 0); chk("R1", "bus", bus, 0); chk("R1", "busy", busy, 0);
        rst_n = 1'b1;

        // R2, R3, R4, R5: direct reads
        cur_tag = "R2";
        valid = 1; mag = 12'hA5C; pol = 1; ovr = 0; cyc(1);
        valid = 0; cs = 1; lo_en = 1; cyc(1);
        chk("R2", "oe", oe, 1); chk("R2", "low byte", bus, 8'h5C);
        cur_tag = "R3";
        hi_en = 1; cyc(1); chk("R3", "both enables", bus, 8'h2A);
        lo_en = 0; cyc(1); chk("R3", "high byte", bus, 8'h2A);
        cur_tag = "R4";
        cs = 0; cyc(1); chk("R4", "no cs oe", oe, 0); chk("R4", "no cs bus", bus, 0);
        cs = 1; hi_en = 0; cyc(1); chk("R4", "no enable oe", oe, 0);
        cur_tag = "R5";
        lo_en = 1; valid = 1; mag = 12'h3C7; pol = 0; ovr = 1; cyc(1);
        chk("R5", "same-cycle read old", bus, 8'h5C);
        valid = 0; cyc(1); chk("R5", "new low", bus, 8'hC7);
        lo_en = 0; hi_en = 1; cyc(1); chk("R5", "new high", bus, 8'h13);

        // R6: mode low
        cur_tag = "R6";
        cs = 0; hi_en = 0; send = 1; valid = 1; mag = 12'h111; cyc(1);
        valid = 0; cyc(3); chk("R6", "no transfer", busy, 0);

        // R7: one-shot arm, R9 send stall, R11 busy window
        cur_tag = "R7";
        mode = 1; cyc(1); mode = 0; cyc(4);
        chk("R7", "armed waits", busy, 0);
        send = 0; valid = 1; mag = 12'h7E1; pol = 1; ovr = 1; cyc(1);
        valid = 0; chk("R11", "busy after start", busy, 1);
        cur_tag = "R9";
        cyc(3); chk("R9", "stall oe", oe, 0);
        send = 1; cyc(1); chk("R9", "hi first oe", oe, 1); chk("R9", "hi first", bus, 8'h37);
        send = 0; cyc(1); chk("R9", "one clock", oe, 0);
        cyc(2); send = 1; cyc(1);
        chk("R9", "lo second", bus, 8'hE1); chk("R11", "busy on lo", busy, 1);
        send = 0; cyc(1); chk("R11", "busy cleared", busy, 0); chk("R11", "oe cleared", oe, 0);
        cur_tag = "R7";
        valid = 1; mag = 12'h555; cyc(1); valid = 0; cyc(2);
        chk("R7", "one shot only", busy, 0);

        // R8 and R10
        cur_tag = "R8";
        mode = 1; send = 1; cs = 1; lo_en = 1; valid = 1; mag = 12'h9AB; pol = 0; ovr = 0; cyc(1);
        chk("R8", "level start", busy, 1); chk("R8", "no direct on start", oe, 0);
        cur_tag = "R10";
        valid = 0; cyc(1); chk("R10", "hi not direct", bus, 8'h09);
        valid = 1; mag = 12'h123; cyc(1); chk("R10", "gap", oe, 0);
        valid = 0; cyc(1); chk("R10", "lo unchanged", bus, 8'hAB);
        cyc(1); chk("R10", "no second start", busy, 0);
        cyc(1); chk("R10", "latch updated", bus, 8'h23);
        cur_tag = "R8";
        cs = 0; lo_en = 0; valid = 1; mag = 12'h456; cyc(1);
        valid = 0; chk("R8", "repeat start", busy, 1);
        cyc(6); mode = 0;

        // Random mixing
        cur_tag = "R9";
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 19) == 0) mode = ~mode;
            cs    = $urandom_range(0, 1);
            lo_en = $urandom_range(0, 1);
            hi_en = ($urandom_range(0, 2) == 0);
            send  = ($urandom_range(0, 2) != 0);
            valid = ($urandom_range(0, 5) == 0);
            mag   = 12'($urandom);
            pol   = $urandom_range(0, 1);
            ovr   = $urandom_range(0, 1);
            cyc(1);
        end
        mode = 0; valid = 0; cs = 0; send = 1; cyc(8);
        finish_run();
    end

endmodule